// File: doc/BRIEF.md
# Display DMA Interrupt Register Block

This block holds the interrupt state of a six-channel display DMA engine. It has two register pairs: a normal bank and an error bank. Each pair has a sticky status word and a mask word. Channel logic raises one-cycle event pulses. Each pulse sets a status bit whose position depends on the event kind and the channel number. Software clears status bits by writing ones to the status word. It changes a mask through two separate write ports: one that unmasks and one that masks.

The block drives one level interrupt line, `irq_o`. The line is registered. It is high when any status bit in either bank is set while its mask bit is clear. Both masks come out of reset fully set over every defined source. The only exception is the vsync bit, which is unmasked from reset.

Register access uses a simple 32-bit bus. Writes are single-cycle strobes. Reads are combinational from the byte offset.

| Offset | Normal bank | Offset | Error bank |
|--------|-------------|--------|------------|
| 0x04 | status | 0x14 | status |
| 0x08 | mask | 0x18 | mask |
| 0x0C | unmask | 0x1C | unmask |
| 0x10 | mask-set | 0x20 | mask-set |

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, both status words read 0x00000000. The normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF, and `irq_o` is 0.
- R2: A pulse on `ev_done[n]` sets normal status bit n. A pulse on `ev_data[n]` sets bit 12+n. A pulse on `ev_vsync` sets bit 27. Bits are set whatever the mask holds, they are visible one clock after the pulse, and they stay set until cleared.
- R3: Error pulses set error status bit base+n. The base is 1 for `err_fetch`, 7 for `err_format`, 13 for `err_crc` and 25 for `err_redone`. Bits are sticky.
- R4: A write to a status word (0x04 or 0x14) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to an unmask port (0x0C or 0x1C) clears the mask bits written as 1. All other mask bits are kept.
- R6: A write to a mask-set port (0x10 or 0x20) sets the mask bits written as 1. All other mask bits are kept.
- R7: A mask offset (0x08 or 0x18) reads back the current mask. The unmask and mask-set offsets read 0. Any other offset reads 0. Writes to the mask offsets themselves, and to any unmapped offset, change nothing.
- R8: If an event pulse and a clearing status write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals, one clock later, the OR of (normal status AND NOT normal mask) and (error status AND NOT error mask).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_done | input | NUM_CH | Per-channel transfer-complete pulses |
| ev_data | input | NUM_CH | Per-channel data-moved pulses |
| ev_vsync | input | 1 | Frame sync pulse |
| err_fetch | input | NUM_CH | Per-channel descriptor read failure pulses |
| err_format | input | NUM_CH | Per-channel bad descriptor header pulses |
| err_crc | input | NUM_CH | Per-channel descriptor checksum mismatch pulses |
| err_redone | input | NUM_CH | Per-channel already-completed descriptor pulses |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench uses the defaults NUM_CH=6 and ADDR_W=8, so every defined source is reachable. That includes the highest channel in each group: bit 17 in the normal bank and bit 30 in the error bank. Channels 0 and 5 are driven side by side, which shows that group bases and channel offsets never overlap. With the 8-bit offset space, the bench can also hit an unmapped offset (0x24) and the mask offsets themselves.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int REG_W = 32;

    // byte offsets of the register words
    localparam int OFF_NSTS = 'h04;
    localparam int OFF_NMSK = 'h08;
    localparam int OFF_NUNM = 'h0C;
    localparam int OFF_NSET = 'h10;
    localparam int OFF_ESTS = 'h14;
    localparam int OFF_EMSK = 'h18;
    localparam int OFF_EUNM = 'h1C;
    localparam int OFF_ESET = 'h20;

    // bit bases decoded by software (valid for up to six channels)
    localparam int BASE_DONE   = 0;
    localparam int BASE_DATA   = 12;
    localparam int BIT_VSYNC   = 27;
    localparam int BASE_FETCH  = 1;
    localparam int BASE_FORMAT = 7;
    localparam int BASE_CRC    = 13;
    localparam int BASE_REDONE = 25;

    localparam logic [REG_W-1:0] NMSK_RST = 32'h07FF_FFFF;
    localparam logic [REG_W-1:0] EMSK_RST = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] msk;
    } bank_t;
endpackage

// File: rtl/dma_irq_event_map.sv
module dma_irq_event_map
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_data,
    input  logic              ev_vsync,
    input  logic [NUM_CH-1:0] err_fetch,
    input  logic [NUM_CH-1:0] err_format,
    input  logic [NUM_CH-1:0] err_crc,
    input  logic [NUM_CH-1:0] err_redone,
    output logic [REG_W-1:0]  nrm_set,
    output logic [REG_W-1:0]  err_set
);
    always_comb begin
        nrm_set = '0;
        err_set = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            nrm_set[BASE_DONE + ch]   = ev_done[ch];
            nrm_set[BASE_DATA + ch]   = ev_data[ch];
            err_set[BASE_FETCH + ch]  = err_fetch[ch];
            err_set[BASE_FORMAT + ch] = err_format[ch];
            err_set[BASE_CRC + ch]    = err_crc[ch];
            err_set[BASE_REDONE + ch] = err_redone[ch];
        end
        nrm_set[BIT_VSYNC] = ev_vsync;
    end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
    import dma_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] MSK_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic             unm_we,
    input  logic             set_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] ev_set,
    output logic [REG_W-1:0] sts_o,
    output logic [REG_W-1:0] msk_o,
    output logic             pend_o
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_we) bank_d.sts = bank_d.sts & ~wdata;
        if (unm_we) bank_d.msk = bank_d.msk & ~wdata;
        if (set_we) bank_d.msk = bank_d.msk | wdata;
        // event applied last: a same-cycle set beats a clear
        bank_d.sts = bank_d.sts | ev_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.sts <= '0;
            bank_q.msk <= MSK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sts_o  = bank_q.sts;
    assign msk_o  = bank_q.msk;
    assign pend_o = |(bank_q.sts & ~bank_q.msk);
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_data,
    input  logic              ev_vsync,
    input  logic [NUM_CH-1:0] err_fetch,
    input  logic [NUM_CH-1:0] err_format,
    input  logic [NUM_CH-1:0] err_crc,
    input  logic [NUM_CH-1:0] err_redone,
    output logic              irq_o
);
    logic [REG_W-1:0] nrm_set, err_set;
    logic [REG_W-1:0] nrm_sts, nrm_msk, err_sts, err_msk;
    logic             nrm_pend, err_pend;
    logic             irq_d, irq_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    dma_irq_event_map #(.NUM_CH(NUM_CH)) u_map (
        .ev_done   (ev_done),
        .ev_data   (ev_data),
        .ev_vsync  (ev_vsync),
        .err_fetch (err_fetch),
        .err_format(err_format),
        .err_crc   (err_crc),
        .err_redone(err_redone),
        .nrm_set   (nrm_set),
        .err_set   (err_set)
    );

    dma_irq_bank #(.MSK_RST(NMSK_RST)) u_nrm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_we(bus_wr && hit(bus_addr, OFF_NSTS)),
        .unm_we(bus_wr && hit(bus_addr, OFF_NUNM)),
        .set_we(bus_wr && hit(bus_addr, OFF_NSET)),
        .wdata (bus_wdata),
        .ev_set(nrm_set),
        .sts_o (nrm_sts),
        .msk_o (nrm_msk),
        .pend_o(nrm_pend)
    );

    dma_irq_bank #(.MSK_RST(EMSK_RST)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_we(bus_wr && hit(bus_addr, OFF_ESTS)),
        .unm_we(bus_wr && hit(bus_addr, OFF_EUNM)),
        .set_we(bus_wr && hit(bus_addr, OFF_ESET)),
        .wdata (bus_wdata),
        .ev_set(err_set),
        .sts_o (err_sts),
        .msk_o (err_msk),
        .pend_o(err_pend)
    );

    always_comb begin
        irq_d = nrm_pend | err_pend;
        bus_rdata = '0;
        if (hit(bus_addr, OFF_NSTS)) bus_rdata = nrm_sts;
        if (hit(bus_addr, OFF_NMSK)) bus_rdata = nrm_msk;
        if (hit(bus_addr, OFF_ESTS)) bus_rdata = err_sts;
        if (hit(bus_addr, OFF_EMSK)) bus_rdata = err_msk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] ev_done,
    input logic [NUM_CH-1:0] ev_data,
    input logic              ev_vsync,
    input logic [NUM_CH-1:0] err_fetch,
    input logic [NUM_CH-1:0] err_format,
    input logic [NUM_CH-1:0] err_crc,
    input logic [NUM_CH-1:0] err_redone,
    input logic              irq_o,
    input logic [REG_W-1:0]  nrm_sts,
    input logic [REG_W-1:0]  nrm_msk,
    input logic [REG_W-1:0]  err_sts,
    input logic [REG_W-1:0]  err_msk
);
    logic quiet;
    assign quiet = !ev_vsync && (ev_done == '0) && (ev_data == '0) &&
                   (err_fetch == '0) && (err_format == '0) &&
                   (err_crc == '0) && (err_redone == '0);

    a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((nrm_sts[BASE_DONE +: NUM_CH] & $past(ev_done)) == $past(ev_done)));

    a_r3_fetch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_sts[BASE_FETCH +: NUM_CH] & $past(err_fetch)) == $past(err_fetch)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_NSTS) && quiet) |=> ((nrm_sts & $past(bus_wdata)) == '0));

    a_r5_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EUNM)) |=> ((err_msk & $past(bus_wdata)) == '0));

    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_NSET)) |=> ((nrm_msk & $past(bus_wdata)) == $past(bus_wdata)));

    a_r7_gate_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_NUNM) || bus_addr == ADDR_W'(OFF_ESET)) |-> (bus_rdata == '0));

    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(((nrm_sts & ~nrm_msk) != '0) || ((err_sts & ~err_msk) != '0))));
endmodule

bind dma_irq_regs dma_irq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_done   (ev_done),
    .ev_data   (ev_data),
    .ev_vsync  (ev_vsync),
    .err_fetch (err_fetch),
    .err_format(err_format),
    .err_crc   (err_crc),
    .err_redone(err_redone),
    .irq_o     (irq_o),
    .nrm_sts   (nrm_sts),
    .nrm_msk   (nrm_msk),
    .err_sts   (err_sts),
    .err_msk   (err_msk)
);

// File: tb/tb_dma_irq_regs.sv
`timescale 1ns/1ps
module tb_dma_irq_regs;
    localparam int NCH = 6;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] ev_done = '0, ev_data = '0;
    logic           ev_vsync = 1'b0;
    logic [NCH-1:0] err_fetch = '0, err_format = '0, err_crc = '0, err_redone = '0;
    logic           irq_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dma_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        bus_addr = AW'(a);
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse_nrm(input logic [NCH-1:0] d, input logic [NCH-1:0] m, input logic v);
        @(negedge clk);
        ev_done = d; ev_data = m; ev_vsync = v;
        @(negedge clk);
        ev_done = '0; ev_data = '0; ev_vsync = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 nrm status", 'h04, 32'h0);
        rd_chk("R1 nrm mask",   'h08, 32'h07FF_FFFF);
        rd_chk("R1 err status", 'h14, 32'h0);
        rd_chk("R1 err mask",   'h18, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_normal();
        // done ch0+ch5 -> bits 0,5; data ch1 -> bit 13
        pulse_nrm(6'b100001, 6'b000010, 1'b0);
        rd_chk("R2 done/data bits", 'h04, 32'h0000_2021);
        @(negedge clk);
        rd_chk("R2 sticky", 'h04, 32'h0000_2021);
        chk("R9 masked no irq", {31'b0, irq_o}, 32'h0);
        pulse_nrm('0, 6'b100000, 1'b1);          // data ch5 -> 17, vsync -> 27
        rd_chk("R2 vsync+data5", 'h04, 32'h0802_2021);
        chk("R9 irq lags one clock", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 irq vsync unmasked", {31'b0, irq_o}, 32'h1);
        wr('h04, 32'h0800_0001);                  // clear vsync and bit 0
        rd_chk("R4 partial clear", 'h04, 32'h0002_2020);
        chk("R9 irq still high 1 clk", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_mask();
        wr('h0C, 32'h0000_0020);
        rd_chk("R5 unmask bit5", 'h08, 32'h07FF_FFDF);
        rd_chk("R7 unmask reads 0", 'h0C, 32'h0);
        @(negedge clk);
        chk("R9 irq after unmask", {31'b0, irq_o}, 32'h1);
        wr('h10, 32'h0000_0020);
        rd_chk("R6 mask bit5", 'h08, 32'h07FF_FFFF);
        rd_chk("R7 mask-set reads 0", 'h10, 32'h0);
        @(negedge clk);
        chk("R9 irq after mask", {31'b0, irq_o}, 32'h0);
        wr('h08, 32'h0);
        rd_chk("R7 direct mask write ignored", 'h08, 32'h07FF_FFFF);
        wr('h24, 32'hFFFF_FFFF);
        rd_chk("R7 unmapped reads 0", 'h24, 32'h0);
        rd_chk("R7 unmapped write no effect", 'h04, 32'h0002_2020);
        wr('h04, 32'hFFFF_FFFF);
        rd_chk("R4 full clear", 'h04, 32'h0);
    endtask

    task automatic t_error();
        @(negedge clk);
        err_fetch = 6'b000001; err_format = 6'b100000;
        err_crc = 6'b000100;   err_redone = 6'b100000;
        @(negedge clk);
        err_fetch = '0; err_format = '0; err_crc = '0; err_redone = '0;
        // bits 1, 12, 15, 30
        rd_chk("R3 error bits", 'h14, 32'h4000_9002);
        @(negedge clk);
        chk("R9 err masked", {31'b0, irq_o}, 32'h0);
        wr('h1C, 32'h4000_0000);
        rd_chk("R5 err unmask", 'h18, 32'hBFFF_FFFF);
        rd_chk("R7 err unmask reads 0", 'h1C, 32'h0);
        @(negedge clk);
        chk("R9 err irq", {31'b0, irq_o}, 32'h1);
        wr('h20, 32'h4000_0000);
        rd_chk("R6 err mask-set", 'h18, 32'hFFFF_FFFF);
        wr('h14, 32'h0000_1002);
        rd_chk("R4 err partial clear", 'h14, 32'h4000_8000);
        wr('h14, 32'hFFFF_FFFF);
        rd_chk("R4 err full clear", 'h14, 32'h0);
    endtask

    task automatic t_collide();
        pulse_nrm('0, 6'b000001, 1'b0);           // bit 12
        rd_chk("R2 data ch0", 'h04, 32'h0000_1000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'('h04); bus_wdata = 32'h0000_1000;
        ev_data = 6'b000001;
        @(negedge clk);
        bus_wr = 1'b0; ev_data = '0;
        rd_chk("R8 set wins over clear", 'h04, 32'h0000_1000);
        @(negedge clk);
        err_crc = 6'b000001;                      // error bit 13
        bus_wr = 1'b1; bus_addr = AW'('h14); bus_wdata = 32'h0000_2000;
        @(negedge clk);
        bus_wr = 1'b0; err_crc = '0;
        rd_chk("R8 err set wins", 'h14, 32'h0000_2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_mask();
        t_error();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule